// File: doc/BRIEF.md
# Serial Peripheral Master with Frame-Select Pulsing

This block is a serial port master that works in one mode only: the clock idles low, input data is captured on rising clock edges and output data changes on falling edges. Software-side logic pushes words into an eight-entry transmit queue. Each word goes out most significant bit first on the serial data output. While it is sent, the serial data input is shifted into a word that lands, right-aligned, in an eight-entry receive queue. An active-low frame-select line frames every word. The clock rate comes from a divider of the system clock. The word length can be set from 4 to 16 bits.

A frame starts when the port is enabled and a word is waiting. The first data bit appears half a serial clock period after frame-select falls, and the first rising edge comes half a period after that. Frame-select rises one full serial clock period after the final capture. If more words are queued, frame-select stays high for exactly one serial clock period before the next frame begins. Divider and word length are sampled at the start of each frame. The output driver can be switched off with the transmit enable. Frames still run in that case, so the receive path keeps working.

Top module: `spi_frame_master`

## Requirements
- R1: After reset and whenever no frame is active, `sclk` is 0, `fss_n` is 1, `sdo` is 0 and `busy` is 0. Straight after reset, `tx_empty` is 1, `tx_not_full` is 1, `rx_not_empty` is 0, `rx_full` is 0 and `rx_ovr` is 0.
- R2: A frame begins, with `fss_n` falling, only while `en` is 1 and a transmit word is waiting. With `en` at 0, a queued word stays queued and `tx_empty` stays 0.
- R3: With H = `div`+1 system clocks, and counting from the cycle in which `fss_n` falls, `sclk` rises at 2H + 2iH and falls at 3H + 2iH for bit i = 0..N-1. The serial clock period is therefore 2H. `sclk` is low at all other times.
- R4: `sdi` is sampled at each rising `sclk` edge. `sdo` changes only at falling `sclk` edges, apart from the first bit, which appears H cycles after `fss_n` falls.
- R5: In a single-word transfer, `fss_n` returns to 1 at (2N+2)H, which is one full serial clock period after the last rising edge.
- R6: When further words are queued, `fss_n` goes high between consecutive words and stays high for exactly 2H cycles before it falls for the next word.
- R7: The word length is N = `wlen_m1`+1. Values of `wlen_m1` below 3 act as 3, which gives 4 bits. Bits N-1 down to 0 of the transmit word are sent MSB first, and higher bits are ignored. `sdo` returns to 0 at the falling edge after the last bit.
- R8: `sdo_oe` equals `tx_en` one cycle later. A 0 means the data output must be left undriven. Frames and reception continue regardless of `tx_en`.
- R9: A received word is the N bits sampled, MSB first, placed in bits N-1..0 of `rx_data`. Bits 15..N are 0.
- R10: Each queue holds 8 words. With `en` at 0, eight writes drop `tx_not_full` to 0, and further writes are ignored. Eight unread received words raise `rx_full`.
- R11: A word that completes while the receive queue is full is discarded and sets `rx_ovr`. `rx_ovr` stays set until reset, and the queued words are unchanged.
- R12: `busy` is 1 from the cycle `fss_n` falls until 2H cycles after `fss_n` rises. If no word follows, it then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; frames start only while high |
| tx_en | input | 1 | Transmit enable; low requests a floating data output |
| div | input | 8 | Half-period divider; H = div+1 system clocks |
| wlen_m1 | input | 4 | Word length minus one (3..15) |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_not_full | output | 1 | Transmit queue can accept a word |
| tx_empty | output | 1 | No transmit word is waiting |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue, right-aligned |
| rx_not_empty | output | 1 | `rx_data` holds a valid unread word |
| rx_full | output | 1 | Receive queue holds 8 words |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| busy | output | 1 | A frame or its trailing high interval is in progress |
| sclk | output | 1 | Serial clock, idle low |
| fss_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| sdi | input | 1 | Serial data input |

## Verification
Every serial event has a fixed distance in system clocks from the cycle in which `fss_n` falls. The first bit appears at H, rising edges come at 2H + 2iH, frame-select is released at (2N+2)H, and the next frame begins or `busy` drops at (2N+4)H. The bench finds the falling edge of `fss_n` and then indexes each later falling system-clock edge by k. At every k it compares `sclk`, `sdo`, `fss_n` and `busy` against values computed from k, H and N. It also drives `sdi` at k so that it is stable before the rising edge that captures it. Received words are read once `rx_not_empty` is seen, and `sdo_oe` is checked one cycle after `tx_en` changes.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  typedef enum logic {ENG_IDLE, ENG_ACT} eng_state_e;
  localparam int unsigned MIN_WORD_BITS = 4;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] q,
  output logic         avail,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          stale;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  // The read register lags a pointer move or a first write by one cycle.
  assign avail = !empty && !stale;
  assign do_wr = wr && !full;
  assign do_rd = rd && avail;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
    q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      stale <= 1'b0;
    end else begin
      if (do_wr) wp <= inc(wp);
      if (do_rd) rp <= inc(rp);
      cnt   <= cnt + CW'(do_wr) - CW'(do_rd);
      stale <= do_rd || (do_wr && empty);
    end
  end

  // R10: a write into a full queue leaves the fill level untouched
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !rd) |=> (cnt == $past(cnt)));
  // R10: an accepted write into a queue that is not read leaves it non-empty
  p_fill_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !full && !rd) |=> !empty);
endmodule

// File: rtl/spi_fm_tick.sv
module spi_fm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R3: the half-period counter never passes the latched divider
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div));
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
  import spi_fm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [LEN_W-1:0]  wlen_m1,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_q,
  input  logic              tick,
  input  logic              sdi,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              nxt_vld,
  output logic              active,
  output logic [DIV_W-1:0]  div_q,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              ovr,
  output logic              sclk,
  output logic              fss_n,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int PH_W = $clog2(2 * DATA_W + 5);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_WORD_BITS - 1);

  eng_state_e        st;
  logic [PH_W-1:0]   ph, np, two_n;
  logic [LEN_W-1:0]  wl_q, wl_in;
  logic [DATA_W-1:0] sh, sh_sl, nxt_word, rx_sh, rx_next, rx_mask;
  logic              start_now, gap_end;

  assign wl_in     = (wlen_m1 < MIN_L) ? MIN_L : wlen_m1;
  assign np        = ph + 1'b1;
  assign two_n     = (PH_W'(wl_q) + 1'b1) << 1;
  assign active    = (st == ENG_ACT);
  assign gap_end   = active && tick && (np == two_n + PH_W'(4));
  assign start_now = en && nxt_vld && ((st == ENG_IDLE) || gap_end);
  assign tx_pop    = en && !nxt_vld && tx_avail;
  assign sh_sl     = sh << 1;
  assign rx_next   = {rx_sh[DATA_W-2:0], sdi};
  assign rx_mask   = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(wl_q));
  assign rx_word   = rx_next & rx_mask;
  assign rx_push   = active && tick && (np == two_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ENG_IDLE;
      ph       <= '0;
      wl_q     <= MIN_L;
      div_q    <= '0;
      sh       <= '0;
      nxt_word <= '0;
      nxt_vld  <= 1'b0;
      rx_sh    <= '0;
      ovr      <= 1'b0;
      sclk     <= 1'b0;
      fss_n    <= 1'b1;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      sdo_oe <= tx_en;
      if (tx_pop) begin
        nxt_word <= tx_q;
        nxt_vld  <= 1'b1;
      end else if (start_now) begin
        nxt_vld <= 1'b0;
      end
      if (rx_push && rx_full) ovr <= 1'b1;

      if (start_now) begin
        st    <= ENG_ACT;
        ph    <= '0;
        fss_n <= 1'b0;
        sclk  <= 1'b0;
        sdo   <= 1'b0;
        sh    <= nxt_word;
        rx_sh <= '0;
        wl_q  <= wl_in;
        div_q <= div;
      end else if (active && tick) begin
        ph <= np;
        if (np == PH_W'(1)) begin
          sdo <= sh[wl_q];
        end else if (!np[0] && (np <= two_n)) begin
          sclk  <= 1'b1;
          rx_sh <= rx_next;
        end else if (np[0] && (np <= two_n + 1'b1)) begin
          sclk <= 1'b0;
          sh   <= sh_sl;
          sdo  <= sh_sl[wl_q];
        end else if (np == two_n + PH_W'(2)) begin
          fss_n <= 1'b1;
        end else if (np == two_n + PH_W'(4)) begin
          st <= ENG_IDLE;
          ph <= '0;
        end
      end
    end
  end

  // R1: idle levels on the serial pins
  p_idle_levels_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_IDLE) |-> (fss_n && !sclk && !sdo));
  // R3: the serial clock toggles only inside a frame
  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !fss_n);
  // R4: output data is steady across a rising edge
  p_sdo_hold_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdo));
  // R5: frame select is released only after a low clock interval
  p_release_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fss_n) |-> (!sclk && $past(!sclk)));
  // R9: a received word is stored on a rising edge
  p_capture_rise_r9: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> sclk);
  // R11: overrun flag is sticky
  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tx_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [3:0]        wlen_m1,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_not_full,
  output logic              tx_empty,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_not_empty,
  output logic              rx_full,
  output logic              rx_ovr,
  output logic              busy,
  output logic              sclk,
  output logic              fss_n,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);
  localparam int LEN_W = $clog2(DATA_W);

  logic              tx_avail, tx_full, tx_fifo_empty, tx_pop, nxt_vld;
  logic [DATA_W-1:0] tx_q, rx_word;
  logic              rx_push, rx_empty, tick, active;
  logic [DIV_W-1:0]  div_q;

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr(tx_wr), .wdata(tx_data), .rd(tx_pop),
    .q(tx_q), .avail(tx_avail), .full(tx_full), .empty(tx_fifo_empty));

  spi_fm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr(rx_push), .wdata(rx_word), .rd(rx_rd),
    .q(rx_data), .avail(rx_not_empty), .full(rx_full), .empty(rx_empty));

  spi_fm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(active), .div(div_q), .tick(tick));

  spi_fm_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .en(en), .tx_en(tx_en), .div(div),
    .wlen_m1(wlen_m1[LEN_W-1:0]), .tx_avail(tx_avail), .tx_q(tx_q),
    .tick(tick), .sdi(sdi), .rx_full(rx_full), .tx_pop(tx_pop),
    .nxt_vld(nxt_vld), .active(active), .div_q(div_q), .rx_push(rx_push),
    .rx_word(rx_word), .ovr(rx_ovr), .sclk(sclk), .fss_n(fss_n),
    .sdo(sdo), .sdo_oe(sdo_oe));

  assign tx_not_full = !tx_full;
  assign tx_empty    = tx_fifo_empty && !nxt_vld;
  assign busy        = active;

  // R8: output enable follows the transmit enable one cycle later
  p_oe_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !sdo_oe);
  // R12: busy covers every low frame-select cycle
  p_busy_frame_r12: assert property (@(posedge clk) disable iff (rst)
    !fss_n |-> busy);
endmodule

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
  logic        clk = 1'b0;
  logic        rst, en, tx_en, tx_wr, rx_rd, sdi;
  logic [7:0]  div;
  logic [3:0]  wlen_m1;
  logic [15:0] tx_data, rx_data;
  logic        tx_not_full, tx_empty, rx_not_empty, rx_full, rx_ovr, busy;
  logic        sclk, fss_n, sdo, sdo_oe;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_frame_master dut (
    .clk(clk), .rst(rst), .en(en), .tx_en(tx_en), .div(div), .wlen_m1(wlen_m1),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_not_full(tx_not_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_not_empty(rx_not_empty), .rx_full(rx_full),
    .rx_ovr(rx_ovr), .busy(busy), .sclk(sclk), .fss_n(fss_n), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(sdi));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int w);
    tx_data = w[15:0];
    tx_wr   = 1'b1;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  task automatic cfg(input int d, input int wl);
    div     = d[7:0];
    wlen_m1 = wl[3:0];
  endtask

  // Follows one frame from the falling edge of fss_n to its release.
  task automatic watch(input int n, input int h, input int txw, input int sdiw);
    int lim = 0, bad_clk = 0, bad_do = 0, bad_fs = 0, bad_bz = 0;
    int endk = (2 * n + 2) * h;
    while (fss_n && lim < 20000) begin @(negedge clk); lim++; end
    chk(!fss_n, "R2 frame start", fss_n, 0);
    for (int k = 0; k <= endk; k++) begin
      int j = (k - h) / (2 * h);
      int i = k / (2 * h);
      bit e_clk = (k >= 2 * h) && (k < (2 * n + 1) * h) && (((k - 2 * h) / h) % 2 == 0);
      bit e_do  = (k >= h) && (j < n) ? txw[n - 1 - j] : 1'b0;
      bit e_fs  = (k == endk);
      if (sclk != e_clk) bad_clk++;
      if (sdo != e_do) bad_do++;
      if (fss_n != e_fs) bad_fs++;
      if (!busy) bad_bz++;
      sdi = (i < n) ? sdiw[n - 1 - i] : 1'b0;
      if (k < endk) @(negedge clk);
    end
    sdi = 1'b0;
    chk(bad_clk == 0, "R3 sclk edge timing", bad_clk, 0);
    chk(bad_do == 0, "R7 R4 sdo bit sequence", bad_do, 0);
    chk(bad_fs == 0, "R5 fss release timing", bad_fs, 0);
    chk(bad_bz == 0, "R12 busy during frame", bad_bz, 0);
  endtask

  task automatic gap(input int h);
    int g = 0;
    while (fss_n && g < 2000) begin @(negedge clk); g++; end
    chk(g == 2 * h, "R6 fss high pulse between words", g, 2 * h);
  endtask

  task automatic tail(input int h);
    for (int j = 1; j <= 2 * h; j++) begin
      @(negedge clk);
      if (j == 2 * h - 1) chk(busy, "R12 busy through trailing interval", busy, 1);
      if (j == 2 * h) chk(!busy, "R12 busy cleared after frame", busy, 0);
    end
  endtask

  task automatic rd_word(input int exp, input string req);
    int lim = 0;
    while (!rx_not_empty && lim < 100) begin @(negedge clk); lim++; end
    chk(rx_not_empty, req, rx_not_empty, 1);
    chk(rx_data == exp[15:0], req, rx_data, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(!sclk, "R1 reset sclk", sclk, 0);
    chk(fss_n, "R1 reset fss_n", fss_n, 1);
    chk(!sdo, "R1 reset sdo", sdo, 0);
    chk(!busy, "R1 reset busy", busy, 0);
    chk(tx_empty && tx_not_full, "R1 reset tx status", {tx_empty, tx_not_full}, 3);
    chk(!rx_not_empty && !rx_full && !rx_ovr, "R1 reset rx status",
        {rx_not_empty, rx_full, rx_ovr}, 0);
  endtask

  task automatic t_single;
    cfg(1, 7);
    wr_word(16'h00A5);
    watch(8, 2, 16'h00A5, 8'h3C);
    tail(2);
    chk(fss_n && !sclk && !sdo, "R1 idle after frame", {fss_n, sclk, sdo}, 4);
    rd_word(16'h003C, "R4 R9 single word received");
  endtask

  task automatic t_long;
    cfg(0, 15);
    wr_word(16'hC3A5);
    watch(16, 1, 16'hC3A5, 16'hB00F);
    tail(1);
    rd_word(16'hB00F, "R9 sixteen-bit word received");
  endtask

  task automatic t_clamp;
    cfg(2, 1);
    wr_word(16'hFFF9);
    watch(4, 3, 16'h0009, 4'hA);
    tail(3);
    rd_word(16'h000A, "R7 R9 clamped four-bit word upper zero");
  endtask

  task automatic t_gate;
    int lows = 0;
    en = 1'b0;
    cfg(0, 7);
    wr_word(16'h0081);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!fss_n || busy) lows++;
    end
    chk(lows == 0, "R2 no frame while disabled", lows, 0);
    chk(!tx_empty, "R2 word still queued", tx_empty, 0);
    en = 1'b1;
    watch(8, 1, 16'h0081, 8'h7E);
    tail(1);
    rd_word(16'h007E, "R2 word sent after enable");
  endtask

  task automatic t_b2b;
    en = 1'b0;
    cfg(1, 5);
    wr_word(16'h002D);
    wr_word(16'h0012);
    wr_word(16'h003F);
    en = 1'b1;
    watch(6, 2, 16'h002D, 6'h11);
    gap(2);
    watch(6, 2, 16'h0012, 6'h2A);
    gap(2);
    watch(6, 2, 16'h003F, 6'h05);
    tail(2);
    rd_word(16'h0011, "R6 first queued word");
    rd_word(16'h002A, "R6 second queued word");
    rd_word(16'h0005, "R6 third queued word");
  endtask

  task automatic t_txoff;
    tx_en = 1'b0;
    @(negedge clk);
    chk(!sdo_oe, "R8 output enable dropped", sdo_oe, 0);
    cfg(0, 7);
    wr_word(16'h0055);
    watch(8, 1, 16'h0055, 8'hC6);
    tail(1);
    rd_word(16'h00C6, "R8 receive with output disabled");
    tx_en = 1'b1;
    @(negedge clk);
    chk(sdo_oe, "R8 output enable restored", sdo_oe, 1);
  endtask

  task automatic t_fill;
    int extra = 0;
    en = 1'b0;
    cfg(0, 3);
    for (int w = 0; w < 9; w++) begin
      wr_word(w + 1);
      if (w == 7) chk(!tx_not_full, "R10 tx full after eight", tx_not_full, 0);
    end
    en = 1'b1;
    for (int f = 0; f < 8; f++) begin
      watch(4, 1, f + 1, (f * 5 + 3) & 15);
      if (f < 7) gap(1);
    end
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (!fss_n) extra++;
    end
    chk(extra == 0, "R10 ninth write ignored", extra, 0);
    chk(rx_full, "R10 rx full after eight", rx_full, 1);
    chk(!rx_ovr, "R11 no overrun yet", rx_ovr, 0);
    wr_word(16'h000C);
    watch(4, 1, 16'h000C, 4'h9);
    tail(1);
    chk(rx_ovr, "R11 overrun flagged", rx_ovr, 1);
    for (int f = 0; f < 8; f++) rd_word((f * 5 + 3) & 15, "R11 queued words kept");
    repeat (3) @(negedge clk);
    chk(!rx_not_empty, "R11 overrun word discarded", rx_not_empty, 0);
    chk(rx_ovr, "R11 overrun sticky", rx_ovr, 1);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; tx_en = 1'b1; tx_wr = 1'b0; rx_rd = 1'b0; sdi = 1'b0;
    div = 8'd0; wlen_m1 = 4'd7; tx_data = 16'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    en = 1'b1;
    @(negedge clk);
    t_single;
    t_long;
    t_clamp;
    t_gate;
    t_b2b;
    t_txoff;
    t_fill;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule